// File: doc/BRIEF.md
# Reservation-Based In-Order Issue Stage

This block is the issue stage of a pipeline whose functional units each have a fixed latency, and those latencies differ. It takes one decoded instruction per cycle over a valid/ready handshake. Each instruction carries an opcode, two source register numbers and a destination register number. Before it accepts an instruction, the stage checks two things. The first is a busy bit held for every architectural register. The second is a timeline of future bookings on the single shared register write port. When both checks pass, the stage reads the operand values, drives them out on a registered issue port, and books both the destination register and the write-port slot where the result will land.

The three execution units are fully pipelined delay lines. They never stall, so a short operation issued after a long one can finish first. Finished results drain through the one write port into the register file and are also shown on a registered writeback port. The stage has no operand forwarding. An instruction that depends on a result waits until that result has been written to the register file.

Top module: `rsv_issue_stage`

## Requirements
- R1: After synchronous reset, `in_ready` is 1, `iss_valid` and `wb_valid` are 0, no register or write-port slot is booked, and every register reads as zero until it is first written.
- R2: Opcodes and latencies are fixed:
  - `in_op` = 0 gives a+b with latency 1.
  - `in_op` = 1 gives ~(a^b) with latency 1.
  - `in_op` = 2 gives the low 32 bits of a*b with latency 3.
  - `in_op` = 3 gives a-b with latency 6.
  
  An instruction accepted at clock edge E shows its result on `wb_valid`/`wb_dst`/`wb_data` after edge E+L, where L is its latency.
- R3: `in_ready` is 0 while the busy bit of `in_src_a`, `in_src_b` or `in_dst` is set. A register's busy bit is set when an instruction that writes it is accepted, and it is cleared at the edge where that result is written. A dependent instruction is therefore accepted no earlier than edge E+L+1.
- R4: `in_ready` is 0 when the write-port slot the presented opcode would use (L edges after acceptance) is already booked by an instruction in flight. The booking timeline is 8 slots deep and moves one slot closer each clock.
- R5: At most one result is written per clock edge. The register file takes the value shown on `wb_data` at the same edge that `wb_valid` rises for it.
- R6: An instruction accepted at edge E (`in_valid` and `in_ready` both 1) appears after edge E on `iss_valid`, `iss_op` and `iss_dst`. Its operand values `iss_opnd_a` and `iss_opnd_b` are the register file contents just before E. When no instruction is accepted, `iss_valid` is 0.
- R7: Units never block. An instruction with no register or write-port conflict is accepted in the cycle it is presented, however many instructions are in flight. `in_ready` does not depend on `in_valid`. Results retire in completion order, not issue order.
- R8: Register 0 always reads as zero and is never marked busy. A result aimed at it still uses the write port and appears on the writeback port with `wb_dst` = 0, but the register keeps reading zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Decoded instruction present |
| in_ready | output | 1 | No hazard for the presented fields |
| in_op | input | 2 | Opcode (0 add, 1 xnor, 2 mul, 3 sub) |
| in_src_a | input | 4 | First source register |
| in_src_b | input | 4 | Second source register |
| in_dst | input | 4 | Destination register |
| iss_valid | output | 1 | Instruction issued last edge |
| iss_op | output | 2 | Issued opcode |
| iss_opnd_a | output | 32 | First operand value |
| iss_opnd_b | output | 32 | Second operand value |
| iss_dst | output | 4 | Issued destination |
| wb_valid | output | 1 | Result written last edge |
| wb_dst | output | 4 | Register written |
| wb_data | output | 32 | Value written |

## Verification
The stage has three results, each due at its own time:
- `in_ready` is combinational, so it is sampled within the same cycle the fields are driven.
- The issue port is due one edge after acceptance.
- The writeback port is due exactly L edges after acceptance, for L of 1, 3 or 6.

The bench keeps a reference queue of future writebacks indexed by edges ahead. Each edge it shifts the queue and files every newly accepted instruction at index L. It compares both registered ports half a cycle after every edge, and checks `in_ready` one time unit after driving the inputs, before the next edge.

// File: rtl/rsv_pkg.sv
package rsv_pkg;

  typedef enum logic [1:0] {
    OP_ADD  = 2'd0,
    OP_XNOR = 2'd1,
    OP_MUL  = 2'd2,
    OP_SUB  = 2'd3
  } op_e;

  localparam int NUM_UNITS = 3;

  // unit 0: short ALU, unit 1: multiplier, unit 2: long unit
  function automatic int unit_of(op_e op);
    case (op)
      OP_ADD, OP_XNOR: return 0;
      OP_MUL:          return 1;
      default:         return 2;
    endcase
  endfunction

endpackage

// File: rtl/rsv_regfile.sv
module rsv_regfile #(
  parameter int NREG = 16,
  parameter int DW   = 32,
  parameter int RW   = $clog2(NREG)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we,
  input  logic [RW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [RW-1:0] raddr_a,
  input  logic [RW-1:0] raddr_b,
  output logic [DW-1:0] rdata_a,
  output logic [DW-1:0] rdata_b
);

  // storage has no reset so it maps onto distributed RAM
  logic [DW-1:0]   mem [NREG];
  logic [NREG-1:0] written_q;

  always_ff @(posedge clk) begin
    if (we && waddr != '0) mem[waddr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (rst) written_q <= '0;
    else if (we && waddr != '0) written_q[waddr] <= 1'b1;
  end

  assign rdata_a = (raddr_a != '0 && written_q[raddr_a]) ? mem[raddr_a] : '0;
  assign rdata_b = (raddr_b != '0 && written_q[raddr_b]) ? mem[raddr_b] : '0;

  AST_R0_NEVER_MARKED: assert property (@(posedge clk) disable iff (rst)
    !written_q[0]) else $error("register 0 recorded as written"); // R8

endmodule

// File: rtl/rsv_busy_table.sv
module rsv_busy_table #(
  parameter int NREG = 16,
  parameter int RW   = $clog2(NREG)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [RW-1:0] chk_a,
  input  logic [RW-1:0] chk_b,
  input  logic [RW-1:0] chk_d,
  input  logic          set_en,
  input  logic [RW-1:0] set_reg,
  input  logic          clr_en,
  input  logic [RW-1:0] clr_reg,
  output logic          hazard
);

  logic [NREG-1:0] busy_q;
  logic [NREG-1:0] busy_d;

  always_comb begin
    busy_d = busy_q;
    if (clr_en) busy_d[clr_reg] = 1'b0;
    if (set_en) busy_d[set_reg] = 1'b1;
    busy_d[0] = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) busy_q <= '0;
    else     busy_q <= busy_d;
  end

  assign hazard = busy_q[chk_a] | busy_q[chk_b] | busy_q[chk_d];

  AST_WB_ONLY_BUSY: assert property (@(posedge clk) disable iff (rst)
    (clr_en && clr_reg != '0) |-> busy_q[clr_reg]) else $error("writeback to idle register"); // R3
  AST_NO_DOUBLE_BOOK: assert property (@(posedge clk) disable iff (rst)
    (set_en && set_reg != '0) |-> !busy_q[set_reg]) else $error("register booked twice"); // R3
  AST_SET_STICKS: assert property (@(posedge clk) disable iff (rst)
    (set_en && set_reg != '0) |=> busy_q[$past(set_reg)]) else $error("booking lost"); // R3

endmodule

// File: rtl/rsv_port_timeline.sv
module rsv_port_timeline #(
  parameter int DEPTH = 8,
  parameter int LW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [LW-1:0] req_lat,
  input  logic          book,
  output logic          slot_taken,
  output logic          due_now
);

  // slot_q[d] set: the port is written at the (d+1)-th upcoming edge
  logic [DEPTH-1:0] slot_q;
  logic [DEPTH-1:0] slot_d;

  always_comb begin
    slot_d = {1'b0, slot_q[DEPTH-1:1]};
    if (book) slot_d[req_lat - LW'(1)] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) slot_q <= '0;
    else     slot_q <= slot_d;
  end

  assign slot_taken = slot_q[req_lat];
  assign due_now    = slot_q[0];

  AST_SLOT_ADVANCES: assert property (@(posedge clk) disable iff (rst)
    (!book && slot_q[1]) |=> slot_q[0]) else $error("booking did not advance"); // R4

endmodule

// File: rtl/rsv_fixed_unit.sv
module rsv_fixed_unit #(
  parameter int LAT = 1,
  parameter int DW  = 32,
  parameter int RW  = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          in_v,
  input  logic [RW-1:0] in_dst,
  input  logic [DW-1:0] in_data,
  output logic          out_v,
  output logic [RW-1:0] out_dst,
  output logic [DW-1:0] out_data
);

  logic          v_q    [LAT];
  logic [RW-1:0] dst_q  [LAT];
  logic [DW-1:0] data_q [LAT];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < LAT; i++) v_q[i] <= 1'b0;
    end else begin
      v_q[0] <= in_v;
      for (int i = 1; i < LAT; i++) v_q[i] <= v_q[i-1];
    end
  end

  always_ff @(posedge clk) begin
    dst_q[0]  <= in_dst;
    data_q[0] <= in_data;
    for (int i = 1; i < LAT; i++) begin
      dst_q[i]  <= dst_q[i-1];
      data_q[i] <= data_q[i-1];
    end
  end

  assign out_v    = v_q[LAT-1];
  assign out_dst  = dst_q[LAT-1];
  assign out_data = data_q[LAT-1];

endmodule

// File: rtl/rsv_issue_stage.sv
module rsv_issue_stage
  import rsv_pkg::*;
#(
  parameter int DW         = 32,
  parameter int NREG       = 16,
  parameter int RW         = $clog2(NREG),
  parameter int LAT_ALU    = 1,
  parameter int LAT_MUL    = 3,
  parameter int LAT_LONG   = 6,
  parameter int PORT_DEPTH = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [1:0]    in_op,
  input  logic [RW-1:0] in_src_a,
  input  logic [RW-1:0] in_src_b,
  input  logic [RW-1:0] in_dst,
  output logic          iss_valid,
  output logic [1:0]    iss_op,
  output logic [DW-1:0] iss_opnd_a,
  output logic [DW-1:0] iss_opnd_b,
  output logic [RW-1:0] iss_dst,
  output logic          wb_valid,
  output logic [RW-1:0] wb_dst,
  output logic [DW-1:0] wb_data
);

  localparam int LW = $clog2(PORT_DEPTH);
  localparam int UNIT_LAT [NUM_UNITS] = '{LAT_ALU, LAT_MUL, LAT_LONG};

  op_e                 op;
  logic [NUM_UNITS-1:0] unit_hit;
  int                  sel_lat;
  logic [LW-1:0]       req_lat;
  logic                reg_hazard, slot_taken, due_now, fire;
  logic [DW-1:0]       opnd_a, opnd_b, result;

  logic                tail_v    [NUM_UNITS];
  logic [RW-1:0]       tail_dst  [NUM_UNITS];
  logic [DW-1:0]       tail_data [NUM_UNITS];
  logic [NUM_UNITS-1:0] tail_vec;
  logic                port_we;
  logic [RW-1:0]       port_dst;
  logic [DW-1:0]       port_data;

  assign op = op_e'(in_op);

  always_comb begin
    unit_hit = '0;
    sel_lat  = LAT_ALU;
    for (int u = 0; u < NUM_UNITS; u++) begin
      if (unit_of(op) == u) begin
        unit_hit[u] = 1'b1;
        sel_lat     = UNIT_LAT[u];
      end
    end
  end
  assign req_lat = LW'(sel_lat);

  // hazard checks
  rsv_busy_table #(.NREG(NREG), .RW(RW)) u_busy (
    .clk(clk), .rst(rst),
    .chk_a(in_src_a), .chk_b(in_src_b), .chk_d(in_dst),
    .set_en(fire), .set_reg(in_dst),
    .clr_en(port_we), .clr_reg(port_dst),
    .hazard(reg_hazard)
  );

  rsv_port_timeline #(.DEPTH(PORT_DEPTH), .LW(LW)) u_port (
    .clk(clk), .rst(rst),
    .req_lat(req_lat), .book(fire),
    .slot_taken(slot_taken), .due_now(due_now)
  );

  assign in_ready = !reg_hazard && !slot_taken;
  assign fire     = in_valid && in_ready;

  // operand read
  rsv_regfile #(.NREG(NREG), .DW(DW), .RW(RW)) u_rf (
    .clk(clk), .rst(rst),
    .we(port_we), .waddr(port_dst), .wdata(port_data),
    .raddr_a(in_src_a), .raddr_b(in_src_b),
    .rdata_a(opnd_a), .rdata_b(opnd_b)
  );

  always_comb begin
    case (op)
      OP_ADD:  result = opnd_a + opnd_b;
      OP_XNOR: result = ~(opnd_a ^ opnd_b);
      OP_MUL:  result = opnd_a * opnd_b;
      default: result = opnd_a - opnd_b;
    endcase
  end

  // fixed-latency units
  for (genvar u = 0; u < NUM_UNITS; u++) begin : g_unit
    rsv_fixed_unit #(.LAT(UNIT_LAT[u]), .DW(DW), .RW(RW)) u_fu (
      .clk(clk), .rst(rst),
      .in_v(fire && unit_hit[u]), .in_dst(in_dst), .in_data(result),
      .out_v(tail_v[u]), .out_dst(tail_dst[u]), .out_data(tail_data[u])
    );
    assign tail_vec[u] = tail_v[u];
  end

  // single write port: bookings guarantee at most one tail is live
  always_comb begin
    port_we   = 1'b0;
    port_dst  = '0;
    port_data = '0;
    for (int u = 0; u < NUM_UNITS; u++) begin
      if (tail_v[u]) begin
        port_we   = 1'b1;
        port_dst  = tail_dst[u];
        port_data = tail_data[u];
      end
    end
  end

  // registered outputs
  always_ff @(posedge clk) begin
    if (rst) begin
      iss_valid <= 1'b0;
      wb_valid  <= 1'b0;
    end else begin
      iss_valid <= fire;
      wb_valid  <= port_we;
    end
  end

  always_ff @(posedge clk) begin
    if (fire) begin
      iss_op     <= in_op;
      iss_opnd_a <= opnd_a;
      iss_opnd_b <= opnd_b;
      iss_dst    <= in_dst;
    end
    if (port_we) begin
      wb_dst  <= port_dst;
      wb_data <= port_data;
    end
  end

  AST_WB_ONEHOT: assert property (@(posedge clk) disable iff (rst)
    $onehot0(tail_vec)) else $error("two results on one port edge"); // R5
  AST_PORT_MATCH: assert property (@(posedge clk) disable iff (rst)
    due_now == port_we) else $error("write port booking mismatch"); // R4
  AST_ISS_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready) |=> iss_valid) else $error("accepted but not issued"); // R6
  AST_ISS_IDLE: assert property (@(posedge clk) disable iff (rst)
    !(in_valid && in_ready) |=> !iss_valid) else $error("issue without acceptance"); // R6
  AST_WB_AFTER_TAIL: assert property (@(posedge clk) disable iff (rst)
    port_we |=> wb_valid) else $error("writeback not shown"); // R2

endmodule

// File: tb/tb_rsv_issue_stage.sv
`timescale 1ns/1ps
module tb_rsv_issue_stage;

  logic        clk = 1'b0;
  logic        rst;
  logic        in_valid;
  logic        in_ready;
  logic [1:0]  in_op;
  logic [3:0]  in_src_a, in_src_b, in_dst;
  logic        iss_valid;
  logic [1:0]  iss_op;
  logic [31:0] iss_opnd_a, iss_opnd_b;
  logic [3:0]  iss_dst;
  logic        wb_valid;
  logic [3:0]  wb_dst;
  logic [31:0] wb_data;

  always #2 clk = ~clk;

  rsv_issue_stage dut (
    .clk(clk), .rst(rst),
    .in_valid(in_valid), .in_ready(in_ready), .in_op(in_op),
    .in_src_a(in_src_a), .in_src_b(in_src_b), .in_dst(in_dst),
    .iss_valid(iss_valid), .iss_op(iss_op), .iss_opnd_a(iss_opnd_a),
    .iss_opnd_b(iss_opnd_b), .iss_dst(iss_dst),
    .wb_valid(wb_valid), .wb_dst(wb_dst), .wb_data(wb_data)
  );

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  // reference state
  logic [31:0] m_reg [16];
  bit          m_busy[16];
  bit          s_v [16];   // index = edges ahead
  logic [3:0]  s_d [16];
  logic [31:0] s_x [16];

  bit          e_iv, e_wv;
  logic [1:0]  e_iop;
  logic [31:0] e_ia, e_ib, e_wx;
  logic [3:0]  e_id, e_wd, e_sa, e_sb;
  bit          last_ready;

  function automatic int lat_of(logic [1:0] op);
    case (op)
      2'd0, 2'd1: return 1;
      2'd2:       return 3;
      default:    return 6;
    endcase
  endfunction

  function automatic logic [31:0] calc(logic [1:0] op, logic [31:0] a, logic [31:0] b);
    case (op)
      2'd0:    return a + b;
      2'd1:    return ~(a ^ b);
      2'd2:    return a * b;
      default: return a - b;
    endcase
  endfunction

  task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: got %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic check_outputs();
    chk("R6", "iss_valid", 32'(iss_valid), 32'(e_iv));
    if (e_iv) begin
      chk("R6", "iss_op", 32'(iss_op), 32'(e_iop));
      chk(e_sa == 0 ? "R8" : "R6", "iss_opnd_a", iss_opnd_a, e_ia);
      chk(e_sb == 0 ? "R8" : "R6", "iss_opnd_b", iss_opnd_b, e_ib);
      chk("R6", "iss_dst", 32'(iss_dst), 32'(e_id));
    end
    chk("R2", "wb_valid", 32'(wb_valid), 32'(e_wv));
    if (e_wv) begin
      chk(e_wd == 0 ? "R8" : "R5", "wb_dst", 32'(wb_dst), 32'(e_wd));
      chk("R5", "wb_data", wb_data, e_wx);
    end
  endtask

  task automatic step(bit v, logic [1:0] op, logic [3:0] a, logic [3:0] b, logic [3:0] d);
    int  l;
    bit  hz_reg, hz_port, er, fire;
    logic [31:0] oa, ob;
    @(negedge clk);
    check_outputs();
    in_valid = v; in_op = op; in_src_a = a; in_src_b = b; in_dst = d;
    #1;
    l       = lat_of(op);
    hz_reg  = m_busy[a] | m_busy[b] | m_busy[d];
    hz_port = s_v[l+1];
    er      = !(hz_reg || hz_port);
    // R7: with no conflict the stage accepts regardless of in-flight work
    chk(hz_port ? "R4" : (hz_reg ? "R3" : "R7"), "in_ready", 32'(in_ready), 32'(er));
    last_ready = er;
    @(posedge clk);
    fire = v && er;
    oa = m_reg[a];
    ob = m_reg[b];
    e_wv = s_v[1]; e_wd = s_d[1]; e_wx = s_x[1];
    if (s_v[1]) begin
      if (s_d[1] != 0) m_reg[s_d[1]] = s_x[1];
      m_busy[s_d[1]] = 0;
    end
    for (int i = 1; i < 15; i++) begin
      s_v[i] = s_v[i+1]; s_d[i] = s_d[i+1]; s_x[i] = s_x[i+1];
    end
    s_v[15] = 0;
    e_iv = fire;
    if (fire) begin
      e_iop = op; e_ia = oa; e_ib = ob; e_id = d; e_sa = a; e_sb = b;
      s_v[l] = 1; s_d[l] = d; s_x[l] = calc(op, oa, ob);
      if (d != 0) m_busy[d] = 1;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [1:0] h_op;
    logic [3:0] h_a, h_b, h_d;
    bit         h_v;
    void'($urandom(32'd20250131));
    for (int i = 0; i < 16; i++) begin
      m_reg[i] = '0; m_busy[i] = 0; s_v[i] = 0; s_d[i] = '0; s_x[i] = '0;
    end
    e_iv = 0; e_wv = 0;
    rst = 1; in_valid = 0; in_op = 0; in_src_a = 0; in_src_b = 0; in_dst = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 0;
    #1;
    // R1 reset state
    chk("R1", "in_ready", 32'(in_ready), 32'd1);
    chk("R1", "iss_valid", 32'(iss_valid), 32'd0);
    chk("R1", "wb_valid", 32'(wb_valid), 32'd0);

    // R1/R8: unwritten registers read zero; ones result
    step(1, 2'd1, 4'd0, 4'd5, 4'd1);   // r1 = ~(0^0)
    // R3: dependent add stalls until r1 written, then issues
    step(1, 2'd0, 4'd1, 4'd1, 4'd2);
    step(1, 2'd0, 4'd1, 4'd1, 4'd2);
    step(1, 2'd0, 4'd1, 4'd1, 4'd2);
    // R7: long sub then short xnor; short retires first
    step(1, 2'd3, 4'd0, 4'd1, 4'd3);
    step(1, 2'd1, 4'd1, 4'd0, 4'd4);
    step(0, 2'd0, 4'd0, 4'd0, 4'd0);
    // R4: write-port collision: sub at E, add at E+5 both want E+6
    step(1, 2'd3, 4'd1, 4'd2, 4'd7);
    step(0, 2'd0, 4'd0, 4'd0, 4'd0);
    step(0, 2'd0, 4'd0, 4'd0, 4'd0);
    step(0, 2'd0, 4'd0, 4'd0, 4'd0);
    step(0, 2'd0, 4'd0, 4'd0, 4'd0);
    step(1, 2'd0, 4'd2, 4'd4, 4'd8);
    step(1, 2'd0, 4'd2, 4'd4, 4'd8);
    // R8: write to r0 then read it back
    step(1, 2'd2, 4'd1, 4'd1, 4'd0);
    step(0, 2'd0, 4'd0, 4'd0, 4'd0);
    step(0, 2'd0, 4'd0, 4'd0, 4'd0);
    step(0, 2'd0, 4'd0, 4'd0, 4'd0);
    step(1, 2'd0, 4'd0, 4'd0, 4'd9);

    // random traffic; a stalled instruction is held until accepted
    h_v = 0; h_op = 0; h_a = 0; h_b = 0; h_d = 0;
    for (int n = 0; n < 4000; n++) begin
      if (!(h_v && !last_ready)) begin
        h_v  = ($urandom % 10) < 8;
        h_op = 2'($urandom % 4);
        h_a  = 4'($urandom % 16);
        h_b  = 4'($urandom % 16);
        h_d  = 4'($urandom % 16);
      end
      step(h_v, h_op, h_a, h_b, h_d);
    end
    for (int n = 0; n < 10; n++) step(0, 2'd0, 4'd0, 4'd0, 4'd0);
    @(negedge clk);
    check_outputs();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule